// File: doc/BRIEF.md
# Dual-Interrupt Event GPIO Bank

A 32-pin general-purpose I/O bank controlled through a 32-bit register bus that accepts byte, halfword and word accesses. Each pin carries a direction bit (1 = input) and an output data bit. Input pins are resynchronised and may watch for a low level, a high level, a rising edge or a falling edge, in any combination. A detected event sets the pin's bit in two independent status registers. Each status register has its own enable register and its own interrupt line, so two consumers can service the same pins separately.

A wakeup request line is raised when a wake-enabled input pin produces an event. The system configuration must permit wakeup and must select a non-zero idle mode. Set and clear alias addresses let software change the enables, the wakeup mask and the output data without a read-modify-write. A configuration bit returns the whole bank to its reset state in one write. The debounce registers are kept for software but do not filter the inputs.

Word offsets used by the bench (byte addresses): 0x00 revision, 0x10 system configuration, 0x14 system status, 0x18 status A, 0x1C enable A, 0x20 wakeup mask, 0x28 status B, 0x2C enable B, 0x30 control, 0x34 direction, 0x38 input data, 0x3C output data, 0x40 low-level detect, 0x44 high-level detect, 0x48 rising detect, 0x4C falling detect, 0x50 debounce enable, 0x54 debounce time. The aliases are:

| Register | Clear alias | Set alias |
|---|---|---|
| enable A | 0x60 | 0x64 |
| enable B | 0x70 | 0x74 |
| wakeup mask | 0x80 | 0x84 |
| output data | 0x90 | 0x94 |

Top module: `evtgpio_bank`

## Requirements
- R1: After reset, the revision word reads the REV_ID parameter (default 0x25) and the system status word reads 1. Control reads 2 and direction reads 0xFFFFFFFF. Status, enables, wakeup mask, detect, debounce, configuration and output data read 0. Both interrupt lines and the wakeup line are low.
- R2: A rising edge on an input pin with its rising-detect bit set, or a falling edge with its falling-detect bit set, sets that pin's bit in both status A and status B. The bits are set by the third clock edge after the pin changes. No other pin's bit is set.
- R3: An input pin held high with its high-level bit set, or held low with its low-level bit set, sets its bit in both status registers. It keeps setting the bit for as long as the level and the enable remain.
- R4: A pin whose direction bit is 0 (output) never sets a status bit. The direction register drives the pin_dir output.
- R5: irq_a is high exactly when status A AND enable A is nonzero, and irq_b likewise for status B and enable B. Clearing one status register does not affect the other.
- R6: Writing 1s to a status register clears those bits. A bit whose pin still meets an enabled level condition stays set through the clear.
- R7: Set aliases OR the written value into enable A, enable B, the wakeup mask or the output data. Clear aliases AND the inverse of the written value into the same register. Reading an alias returns its register. pin_out follows the output data register.
- R8: A byte (size 0) or halfword (size 1) write to an ordinary register places the data at the byte lane given by address bits 1:0. The bytes outside the written lanes keep their old contents.
- R9: A sub-word write to a status or alias address acts as a word write whose unwritten lanes are zero.
- R10: A read returns the addressed word shifted right by 8 times address bits 1:0.
- R11: A write to system configuration stores the value AND 0x1D. If the written value has bit 1 set, the bank returns to its reset values except output data. Control keeps 3 bits and debounce time keeps 8 bits.
- R12: wake_req pulses high for one cycle after a detection event on a wake-enabled pin. This happens only while configuration bit 2 is 1 and configuration bits 4:3 are nonzero.
- R13: The input data word reads the synchronised pin levels. Writes to the revision, system status and input data words have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bank clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the current bus cycle |
| addr | input | 8 | Byte address |
| size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| wdata | input | 32 | Write data, right-aligned |
| rdata | output | 32 | Read data for addr and size |
| pin_in | input | 32 | Pin levels, asynchronous |
| pin_out | output | 32 | Output data register |
| pin_dir | output | 32 | Direction register, 1 = input |
| irq_a | output | 1 | Interrupt line of status/enable pair A |
| irq_b | output | 1 | Interrupt line of status/enable pair B |
| wake_req | output | 1 | Wakeup request pulse |

## Verification
The bench builds the bank with its defaults: REV_ID 0x25 and two synchroniser stages. This makes the detection latency exactly three edges. Every one of the 32 pins is swept through both edge polarities, and each sweep checks that only the addressed bit appears in both status registers. Sub-word merging and zero-fill are exercised at non-zero byte lanes, where the two policies produce different words. The wakeup gating is tried with each of its three conditions removed in turn.

// File: rtl/evtgpio_pkg.sv
package evtgpio_pkg;

    localparam int BUS_W = 32;

    typedef enum logic [5:0] {
        W_REV      = 6'h00,
        W_SYSCFG   = 6'h04,
        W_SYSSTAT  = 6'h05,
        W_STAT_A   = 6'h06,
        W_EN_A     = 6'h07,
        W_WAKE     = 6'h08,
        W_STAT_B   = 6'h0A,
        W_EN_B     = 6'h0B,
        W_CTRL     = 6'h0C,
        W_DIR      = 6'h0D,
        W_DIN      = 6'h0E,
        W_DOUT     = 6'h0F,
        W_LVL_LO   = 6'h10,
        W_LVL_HI   = 6'h11,
        W_RISE     = 6'h12,
        W_FALL     = 6'h13,
        W_DB_EN    = 6'h14,
        W_DB_TIME  = 6'h15,
        W_EN_A_CLR = 6'h18,
        W_EN_A_SET = 6'h19,
        W_EN_B_CLR = 6'h1C,
        W_EN_B_SET = 6'h1D,
        W_WAKE_CLR = 6'h20,
        W_WAKE_SET = 6'h21,
        W_DOUT_CLR = 6'h24,
        W_DOUT_SET = 6'h25
    } reg_word_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } acc_size_e;

    function automatic logic [BUS_W-1:0] size_lanes(input logic [1:0] sz);
        case (sz)
            SZ_BYTE: size_lanes = BUS_W'(32'h0000_00FF);
            SZ_HALF: size_lanes = BUS_W'(32'h0000_FFFF);
            default: size_lanes = '1;
        endcase
    endfunction

endpackage

// File: rtl/evtgpio_sync.sv
module evtgpio_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] q_out
);
    logic [WIDTH-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[s] <= '0;
                else        stg[s] <= d_in;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[s] <= '0;
                else        stg[s] <= stg[s-1];
            end
        end
    end

    assign q_out = stg[STAGES-1];
endmodule

// File: rtl/evtgpio_detect.sv
module evtgpio_detect #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] lvl_now,
    input  logic [WIDTH-1:0] lvl_prev,
    input  logic [WIDTH-1:0] is_input,
    input  logic [WIDTH-1:0] on_low,
    input  logic [WIDTH-1:0] on_high,
    input  logic [WIDTH-1:0] on_rise,
    input  logic [WIDTH-1:0] on_fall,
    output logic [WIDTH-1:0] hit
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        logic rose, fell, held;
        assign rose   = lvl_now[i] & ~lvl_prev[i] & on_rise[i];
        assign fell   = ~lvl_now[i] & lvl_prev[i] & on_fall[i];
        assign held   = lvl_now[i] ? on_high[i] : on_low[i];
        assign hit[i] = is_input[i] & (rose | fell | held);
    end
endmodule

// File: rtl/evtgpio_checker.sv
module evtgpio_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [7:0]  addr,
    input logic [1:0]  size,
    input logic [31:0] wdata,
    input logic [31:0] st_a,
    input logic [31:0] st_b,
    input logic [31:0] en_a,
    input logic [31:0] dir,
    input logic [4:0]  cfg,
    input logic        wake_req
);
    // R2: any bit newly raised in status A is also present in status B
    p_dual_status_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_a & ~$past(st_a) & ~st_b) == 32'h0);

    // R4: output pins never raise a status bit
    p_output_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_a & ~$past(st_a) & ~$past(dir)) == 32'h0);

    // R7: word write to the set alias of enable A ORs in the data
    p_alias_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 8'h64 && size == 2'd2)
        |=> en_a == ($past(en_a) | $past(wdata)));

    // R11: configuration write with bit 1 restores enables and direction
    p_soft_reset_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 8'h10 && size == 2'd2 && wdata[1])
        |=> (en_a == 32'h0 && dir == 32'hFFFF_FFFF));

    // R12: wakeup only under the permitting configuration
    p_wake_gate_r12: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> ($past(cfg[2]) && $past(cfg[4:3]) != 2'b00));
endmodule

bind evtgpio_bank evtgpio_checker u_evtgpio_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .size     (size),
    .wdata    (wdata),
    .st_a     (st_a),
    .st_b     (st_b),
    .en_a     (en_a),
    .dir      (dir_q),
    .cfg      (cfg_q),
    .wake_req (wake_req)
);

// File: rtl/evtgpio_bank.sv
module evtgpio_bank
    import evtgpio_pkg::*;
#(
    parameter logic [7:0] REV_ID      = 8'h25,
    parameter int         SYNC_STAGES = 2,
    parameter logic [2:0] CTRL_RST    = 3'd2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [7:0]  addr,
    input  logic [1:0]  size,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    input  logic [31:0] pin_in,
    output logic [31:0] pin_out,
    output logic [31:0] pin_dir,
    output logic        irq_a,
    output logic        irq_b,
    output logic        wake_req
);
    localparam int         W        = BUS_W;
    localparam logic [4:0] CFG_KEEP = 5'h1D;

    // register state
    logic [4:0]   cfg_q;
    logic [2:0]   ctrl_q;
    logic [7:0]   db_time;
    logic [W-1:0] st_a, st_b, en_a, en_b, wake_en;
    logic [W-1:0] dir_q, dout_q, lvl_lo, lvl_hi, rise_en, fall_en, db_en;

    // input path
    logic [W-1:0] pin_s, pin_p, hit;

    evtgpio_sync #(.WIDTH(W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (pin_in),
        .q_out (pin_s)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin_p <= '0;
        else        pin_p <= pin_s;
    end

    evtgpio_detect #(.WIDTH(W)) u_detect (
        .lvl_now  (pin_s),
        .lvl_prev (pin_p),
        .is_input (dir_q),
        .on_low   (lvl_lo),
        .on_high  (lvl_hi),
        .on_rise  (rise_en),
        .on_fall  (fall_en),
        .hit      (hit)
    );

    // bus decode
    reg_word_e    widx;
    logic [4:0]   shamt;
    logic [W-1:0] lanes, wv, cur, merged, zfill, clr_a, clr_b;
    logic         soft_rst;

    assign widx  = reg_word_e'(addr[7:2]);
    assign shamt = {addr[1:0], 3'b000};
    assign lanes = size_lanes(size) << shamt;
    assign wv    = wdata << shamt;

    always_comb begin
        case (widx)
            W_REV:                  cur = W'(REV_ID);
            W_SYSCFG:               cur = W'(cfg_q);
            W_SYSSTAT:              cur = W'(1);
            W_STAT_A:               cur = st_a;
            W_EN_A, W_EN_A_CLR,
            W_EN_A_SET:             cur = en_a;
            W_WAKE, W_WAKE_CLR,
            W_WAKE_SET:             cur = wake_en;
            W_STAT_B:               cur = st_b;
            W_EN_B, W_EN_B_CLR,
            W_EN_B_SET:             cur = en_b;
            W_CTRL:                 cur = W'(ctrl_q);
            W_DIR:                  cur = dir_q;
            W_DIN:                  cur = pin_s;
            W_DOUT, W_DOUT_CLR,
            W_DOUT_SET:             cur = dout_q;
            W_LVL_LO:               cur = lvl_lo;
            W_LVL_HI:               cur = lvl_hi;
            W_RISE:                 cur = rise_en;
            W_FALL:                 cur = fall_en;
            W_DB_EN:                cur = db_en;
            W_DB_TIME:              cur = W'(db_time);
            default:                cur = '0;
        endcase
    end

    assign rdata    = cur >> shamt;
    assign merged   = (cur & ~lanes) | (wv & lanes);
    assign zfill    = wv & lanes;
    assign soft_rst = wr_en && (widx == W_SYSCFG) && merged[1];
    assign clr_a    = (wr_en && widx == W_STAT_A) ? zfill : '0;
    assign clr_b    = (wr_en && widx == W_STAT_B) ? zfill : '0;

    // register update
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q   <= '0;
            ctrl_q  <= CTRL_RST;
            db_time <= '0;
            st_a    <= '0;
            st_b    <= '0;
            en_a    <= '0;
            en_b    <= '0;
            wake_en <= '0;
            dir_q   <= '1;
            dout_q  <= '0;
            lvl_lo  <= '0;
            lvl_hi  <= '0;
            rise_en <= '0;
            fall_en <= '0;
            db_en   <= '0;
        end else if (soft_rst) begin
            cfg_q   <= merged[4:0] & CFG_KEEP;
            ctrl_q  <= CTRL_RST;
            db_time <= '0;
            st_a    <= '0;
            st_b    <= '0;
            en_a    <= '0;
            en_b    <= '0;
            wake_en <= '0;
            dir_q   <= '1;
            lvl_lo  <= '0;
            lvl_hi  <= '0;
            rise_en <= '0;
            fall_en <= '0;
            db_en   <= '0;
        end else begin
            st_a <= (st_a & ~clr_a) | hit;
            st_b <= (st_b & ~clr_b) | hit;
            if (wr_en) begin
                case (widx)
                    W_SYSCFG:   cfg_q   <= merged[4:0] & CFG_KEEP;
                    W_EN_A:     en_a    <= merged;
                    W_EN_A_CLR: en_a    <= en_a & ~zfill;
                    W_EN_A_SET: en_a    <= en_a | zfill;
                    W_EN_B:     en_b    <= merged;
                    W_EN_B_CLR: en_b    <= en_b & ~zfill;
                    W_EN_B_SET: en_b    <= en_b | zfill;
                    W_WAKE:     wake_en <= merged;
                    W_WAKE_CLR: wake_en <= wake_en & ~zfill;
                    W_WAKE_SET: wake_en <= wake_en | zfill;
                    W_CTRL:     ctrl_q  <= merged[2:0];
                    W_DIR:      dir_q   <= merged;
                    W_DOUT:     dout_q  <= merged;
                    W_DOUT_CLR: dout_q  <= dout_q & ~zfill;
                    W_DOUT_SET: dout_q  <= dout_q | zfill;
                    W_LVL_LO:   lvl_lo  <= merged;
                    W_LVL_HI:   lvl_hi  <= merged;
                    W_RISE:     rise_en <= merged;
                    W_FALL:     fall_en <= merged;
                    W_DB_EN:    db_en   <= merged;
                    W_DB_TIME:  db_time <= merged[7:0];
                    default:    ;
                endcase
            end
        end
    end

    // wakeup pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wake_req <= 1'b0;
        else        wake_req <= (|(hit & wake_en)) & cfg_q[2] & (|cfg_q[4:3]);
    end

    assign irq_a   = |(st_a & en_a);
    assign irq_b   = |(st_b & en_b);
    assign pin_out = dout_q;
    assign pin_dir = dir_q;
endmodule

// File: tb/evtgpio_bank_bench.sv
`timescale 1ns/1ps
module evtgpio_bank_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [1:0]  size = 2'd2;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out, pin_dir;
    logic        irq_a, irq_b, wake_req;

    int checks = 0;
    int errors = 0;
    int wake_cnt = 0;
    logic [31:0] exp_dout;

    always #2 clk = ~clk;

    evtgpio_bank u_evtgpio_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .size(size),
        .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out),
        .pin_dir(pin_dir), .irq_a(irq_a), .irq_b(irq_b), .wake_req(wake_req)
    );

    always @(negedge clk) if (rst_n && wake_req) wake_cnt++;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        addr = a; size = s; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [1:0] s, output logic [31:0] d);
        @(negedge clk);
        addr = a; size = s; wr_en = 1'b0;
        #1 d = rdata;
    endtask

    task automatic chk_reg(input string tag, input logic [7:0] a, input logic [1:0] s,
                           input logic [31:0] exp);
        logic [31:0] v;
        rd(a, s, v);
        chk(tag, v, exp);
    endtask

    task automatic clear_status();
        wr(8'h18, 2'd2, 32'hFFFF_FFFF);
        wr(8'h28, 2'd2, 32'hFFFF_FFFF);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(1);

        // R1 reset state
        chk_reg("R1 revision", 8'h00, 2'd2, 32'h25);
        chk_reg("R1 sysstatus", 8'h14, 2'd2, 32'h1);
        chk_reg("R1 control", 8'h30, 2'd2, 32'h2);
        chk_reg("R1 direction", 8'h34, 2'd2, 32'hFFFF_FFFF);
        chk_reg("R1 status A", 8'h18, 2'd2, 32'h0);
        chk_reg("R1 output data", 8'h3C, 2'd2, 32'h0);
        chk("R1 lines", {29'b0, irq_a, irq_b, wake_req}, 32'h0);

        // R13 input data and read-only words
        pin_in = 32'hA5A5_0F0F;
        wait_clk(4);
        chk_reg("R13 input data", 8'h38, 2'd2, 32'hA5A5_0F0F);
        wr(8'h38, 2'd2, 32'h0);
        chk_reg("R13 input data write ignored", 8'h38, 2'd2, 32'hA5A5_0F0F);
        wr(8'h00, 2'd2, 32'hFFFF_FFFF);
        chk_reg("R13 revision write ignored", 8'h00, 2'd2, 32'h25);
        wr(8'h3C, 2'd2, 32'h1234_5678);
        exp_dout = 32'h1234_5678;
        chk("R7 pin_out follows output data", pin_out, exp_dout);

        pin_in = '0;
        wait_clk(4);
        clear_status();

        // R2 rising sweep over all pins
        for (int i = 0; i < 32; i++) begin
            logic [31:0] va, vb;
            wr(8'h48, 2'd2, 32'h1 << i);
            pin_in = 32'h1 << i;
            wait_clk(4);
            rd(8'h18, 2'd2, va);
            rd(8'h28, 2'd2, vb);
            chk($sformatf("R2 rising pin %0d status A", i), va, 32'h1 << i);
            chk($sformatf("R2 rising pin %0d status B", i), vb, 32'h1 << i);
            pin_in = '0;
            wait_clk(4);
            wr(8'h48, 2'd2, 32'h0);
            clear_status();
        end

        // R2 falling sweep
        pin_in = 32'hFFFF_FFFF;
        wait_clk(4);
        for (int i = 0; i < 32; i++) begin
            logic [31:0] va, vb;
            wr(8'h4C, 2'd2, 32'h1 << i);
            pin_in = ~(32'h1 << i);
            wait_clk(4);
            rd(8'h18, 2'd2, va);
            rd(8'h28, 2'd2, vb);
            chk($sformatf("R2 falling pin %0d status A", i), va, 32'h1 << i);
            chk($sformatf("R2 falling pin %0d status B", i), vb, 32'h1 << i);
            pin_in = 32'hFFFF_FFFF;
            wait_clk(4);
            wr(8'h4C, 2'd2, 32'h0);
            clear_status();
        end

        // R4 output pins ignored
        pin_in = '0;
        wait_clk(4);
        wr(8'h34, 2'd2, 32'hFFFF_FFDF);
        chk("R4 pin_dir", pin_dir, 32'hFFFF_FFDF);
        wr(8'h48, 2'd2, 32'h60);
        pin_in = 32'h60;
        wait_clk(4);
        chk_reg("R4 output pin no status", 8'h18, 2'd2, 32'h40);
        wr(8'h48, 2'd2, 32'h0);
        wr(8'h34, 2'd2, 32'hFFFF_FFFF);

        // R5 two interrupt pairs
        wr(8'h1C, 2'd2, 32'h40);
        chk("R5 irq_a on", {31'b0, irq_a}, 32'h1);
        chk("R5 irq_b off", {31'b0, irq_b}, 32'h0);
        wr(8'h2C, 2'd2, 32'h40);
        chk("R5 irq_b on", {31'b0, irq_b}, 32'h1);
        wr(8'h28, 2'd2, 32'h40);
        wait_clk(1);
        chk("R5 irq_b cleared", {31'b0, irq_b}, 32'h0);
        chk("R5 irq_a unaffected", {31'b0, irq_a}, 32'h1);
        chk_reg("R5 status A kept", 8'h18, 2'd2, 32'h40);
        wr(8'h18, 2'd2, 32'h40);
        wait_clk(1);
        chk("R5 irq_a cleared", {31'b0, irq_a}, 32'h0);
        wr(8'h1C, 2'd2, 32'h0);
        wr(8'h2C, 2'd2, 32'h0);

        // R3 / R6 level detection and reassertion
        wr(8'h44, 2'd2, 32'h40);
        wait_clk(2);
        chk_reg("R3 high level status A", 8'h18, 2'd2, 32'h40);
        chk_reg("R3 high level status B", 8'h28, 2'd2, 32'h40);
        wr(8'h18, 2'd2, 32'h40);
        wait_clk(1);
        chk_reg("R6 level reasserts", 8'h18, 2'd2, 32'h40);
        wr(8'h40, 2'd2, 32'h80);
        wait_clk(2);
        chk_reg("R3 low level", 8'h18, 2'd2, 32'hC0);
        wr(8'h44, 2'd2, 32'h0);
        wr(8'h40, 2'd2, 32'h0);
        clear_status();
        wait_clk(1);
        chk_reg("R6 clear without level", 8'h18, 2'd2, 32'h0);

        // R7 aliases
        wr(8'h64, 2'd2, 32'hF0);
        chk_reg("R7 set enable A", 8'h1C, 2'd2, 32'hF0);
        chk_reg("R7 alias read", 8'h64, 2'd2, 32'hF0);
        wr(8'h60, 2'd2, 32'h30);
        chk_reg("R7 clear enable A", 8'h1C, 2'd2, 32'hC0);
        wr(8'h74, 2'd2, 32'h0F0F);
        wr(8'h70, 2'd2, 32'h000F);
        chk_reg("R7 enable B aliases", 8'h74, 2'd2, 32'h0F00);
        wr(8'h84, 2'd2, 32'hA);
        wr(8'h80, 2'd2, 32'h2);
        chk_reg("R7 wakeup aliases", 8'h20, 2'd2, 32'h8);
        wr(8'h94, 2'd2, 32'h8000_0001);
        wr(8'h90, 2'd2, 32'h0000_0078);
        exp_dout = (exp_dout | 32'h8000_0001) & ~32'h78;
        chk("R7 output data aliases", pin_out, exp_dout);
        wr(8'h1C, 2'd2, 32'h0);
        wr(8'h2C, 2'd2, 32'h0);
        wr(8'h20, 2'd2, 32'h0);

        // R8 merge, R10 shifted reads
        wr(8'h50, 2'd2, 32'h1122_3344);
        wr(8'h51, 2'd0, 32'hAB);
        chk_reg("R8 byte merge", 8'h50, 2'd2, 32'h1122_AB44);
        wr(8'h52, 2'd1, 32'hBEEF);
        chk_reg("R8 half merge", 8'h50, 2'd2, 32'hBEEF_AB44);
        chk_reg("R10 byte read lane 3", 8'h53, 2'd0, 32'h0000_00BE);
        chk_reg("R10 half read lane 2", 8'h52, 2'd1, 32'h0000_BEEF);
        chk_reg("R10 byte read lane 1", 8'h51, 2'd0, 32'h00BE_EFAB);
        wr(8'h54, 2'd2, 32'h1FF);
        chk_reg("R11 debounce time 8 bits", 8'h54, 2'd2, 32'hFF);

        // R9 zero-fill on alias
        wr(8'h1C, 2'd2, 32'hFFFF_0000);
        wr(8'h65, 2'd0, 32'h01);
        chk_reg("R9 set alias byte", 8'h1C, 2'd2, 32'hFFFF_0100);
        wr(8'h62, 2'd0, 32'h0F);
        chk_reg("R9 clear alias byte", 8'h1C, 2'd2, 32'hFFF0_0100);
        wr(8'h1C, 2'd2, 32'h0);

        // R12 wakeup gating
        pin_in = '0;
        wait_clk(4);
        clear_status();
        wake_cnt = 0;
        wr(8'h84, 2'd2, 32'h100);
        wr(8'h10, 2'd2, 32'h0C);
        wr(8'h48, 2'd2, 32'h100);
        pin_in = 32'h100;
        wait_clk(5);
        chk("R12 wake pulse", wake_cnt, 32'd1);
        pin_in = '0; wait_clk(4);
        wr(8'h10, 2'd2, 32'h04);
        pin_in = 32'h100; wait_clk(5);
        chk("R12 no wake with idle mode 0", wake_cnt, 32'd1);
        pin_in = '0; wait_clk(4);
        wr(8'h10, 2'd2, 32'h08);
        pin_in = 32'h100; wait_clk(5);
        chk("R12 no wake without enable bit", wake_cnt, 32'd1);
        pin_in = '0; wait_clk(4);
        wr(8'h10, 2'd2, 32'h0C);
        wr(8'h80, 2'd2, 32'h100);
        pin_in = 32'h100; wait_clk(5);
        chk("R12 no wake when pin masked", wake_cnt, 32'd1);
        wr(8'h48, 2'd2, 32'h0);
        clear_status();

        // R11 configuration and soft reset
        wr(8'h30, 2'd2, 32'hFF);
        chk_reg("R11 control 3 bits", 8'h30, 2'd2, 32'h7);
        wr(8'h1C, 2'd2, 32'hF);
        wr(8'h34, 2'd2, 32'h0);
        wr(8'h10, 2'd2, 32'hFF);
        chk_reg("R11 config masked", 8'h10, 2'd2, 32'h1D);
        chk_reg("R11 soft reset control", 8'h30, 2'd2, 32'h2);
        chk_reg("R11 soft reset enable A", 8'h1C, 2'd2, 32'h0);
        chk_reg("R11 soft reset direction", 8'h34, 2'd2, 32'hFFFF_FFFF);
        chk_reg("R11 soft reset debounce", 8'h50, 2'd2, 32'h0);
        chk_reg("R11 output data kept", 8'h3C, 2'd2, exp_dout);

        finish_run();
    end
endmodule